// File: doc/BRIEF.md
# Two-Dimensional Modulo Address Stepper

This block sequences a DMA transfer as a rectangle instead of a flat run. When a descriptor is loaded with the stepping feature switched on and at least one channel asking for it, the two bytes of the length field stop being one 16-bit count. The low byte becomes a column limit and the high byte becomes a row limit, and two counters take over. Each time the data path reports a finished element, the column counter advances. When a row is complete, a 16-bit skip value is added to the offset of every channel that asked for the skip. Channels that did not ask for it keep stepping linearly.

The data path reports element completion with a one-cycle strobe. For each channel it receives the current 16-bit offset and gets back the addend and the offset after the skip. The stepper signals the end of the transfer. When the descriptor does not select this mode, the block forwards the data path's own end-of-length condition without change.

Top module: `mod_stepper`

## Requirements
- R1: Modulo mode is chosen at descriptor load only if `mod_feature_en` is 1 and at least one bit of `desc_chan_mod` is 1. `mod_active` shows this choice until the next load. While it is 0, `xfer_end` equals `lin_done` and every addend is zero.
- R2: A column limit byte or row limit byte of zero is treated as 256.
- R3: A descriptor load resets the column and row counters to zero. The first row skip after a load therefore comes on element number (column limit + 1).
- R4: On an element strobe in modulo mode, a column counter below its limit increments. A column counter at its limit goes back to zero and the row counter increments. In that same cycle, `chan_addend` equals the skip value for each channel whose flag was set at load, and zero for the other channels. In all other cycles the addend is zero.
- R5: `xfer_end` pulses for one cycle on the element strobe that finds both counters at their limits. This is element number (column limit + 1) × (row limit + 1).
- R6: `chan_off_out` equals `chan_off_in` plus that channel's addend, modulo 65536. Only the 16-bit offset is affected.
- R7: After a modulo transfer has ended, further element strobes produce no addend and no `xfer_end` until the next load.
- R8: If `desc_load` and `elem_done` are both high in the same cycle, the load takes effect and the strobe is not counted.
- R9: The skip value is {`desc_mod_hi`, `desc_mod_lo`}, with the low byte as bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_feature_en | input | 1 | Global switch that allows modulo stepping |
| desc_load | input | 1 | Load strobe for the descriptor fields |
| desc_len_lo | input | 8 | Low length byte; used as the column limit |
| desc_len_hi | input | 8 | High length byte; used as the row limit |
| desc_mod_lo | input | 8 | Skip value, bits 7:0 |
| desc_mod_hi | input | 8 | Skip value, bits 15:8 |
| desc_chan_mod | input | NCH | Per-channel modulo request; bit 0 is the source, bit 1 the target |
| elem_done | input | 1 | One element has been completed |
| lin_done | input | 1 | End-of-length condition from the linear counter |
| chan_off_in | input | NCH*16 | Current 16-bit offset of each channel |
| chan_addend | output | NCH*16 | Skip amount to add to each channel in this cycle |
| chan_off_out | output | NCH*16 | Offset of each channel after the skip |
| mod_active | output | 1 | Current descriptor uses modulo stepping |
| xfer_end | output | 1 | Transfer ends with this element |

## Verification
Some properties are checked on every clock cycle. The counters never pass their limits, and a cleared counter reads zero. An addend appears only on an element strobe in modulo mode. An end pulse always leaves the stepper idle, and an idle stepper stays quiet. The bench scenarios are the only check of the exact element on which each row skip and the end fall. They are also the only check of the 256 expansion for both limit bytes, the offset wrap past 0xFFFF, the order of the skip value's bytes, and how a load and a strobe in the same cycle interact.

// File: rtl/mod_stepper_pkg.sv
package mod_stepper_pkg;

    localparam int BYTE_W = 8;
    localparam int OFF_W  = 16;
    localparam int LIM_W  = BYTE_W + 1;

    typedef struct packed {
        logic             mode;
        logic             busy;
        logic [OFF_W-1:0] skip;
    } step_state_t;

    function automatic logic [LIM_W-1:0] expand_limit(input logic [BYTE_W-1:0] raw);
        logic [LIM_W-1:0] r;
        if (raw == '0) r = LIM_W'(1) << BYTE_W;
        else           r = {1'b0, raw};
        return r;
    endfunction

endpackage

// File: rtl/mod_axis_counter.sv
module mod_axis_counter
    import mod_stepper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [BYTE_W-1:0] lim_raw,
    input  logic              adv,
    output logic              at_lim
);
    logic [LIM_W-1:0] cnt_q;
    logic [LIM_W-1:0] lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= expand_limit('0);
        end else if (clear) begin
            cnt_q <= '0;
            lim_q <= expand_limit(lim_raw);
        end else if (adv) begin
            if (cnt_q == lim_q) cnt_q <= '0;
            else                cnt_q <= cnt_q + LIM_W'(1);
        end
    end

    assign at_lim = (cnt_q == lim_q);

    // R4: the counter never runs past its limit
    a_r4_cnt_within_lim: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim_q);
    // R2: a latched limit is never zero
    a_r2_lim_nonzero: assert property (@(posedge clk) disable iff (rst)
        lim_q != '0);
    // R3: a clear leaves the counter at zero
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear |=> cnt_q == '0);

endmodule

// File: rtl/mod_chan_skip.sv
module mod_chan_skip
    import mod_stepper_pkg::*;
(
    input  logic             flag,
    input  logic             row_step,
    input  logic [OFF_W-1:0] skip,
    input  logic [OFF_W-1:0] off_in,
    output logic [OFF_W-1:0] addend,
    output logic [OFF_W-1:0] off_out
);
    always_comb begin
        addend  = (row_step && flag) ? skip : '0;
        off_out = off_in + addend;
    end
endmodule

// File: rtl/mod_stepper.sv
module mod_stepper
    import mod_stepper_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mod_feature_en,
    input  logic                 desc_load,
    input  logic [7:0]           desc_len_lo,
    input  logic [7:0]           desc_len_hi,
    input  logic [7:0]           desc_mod_lo,
    input  logic [7:0]           desc_mod_hi,
    input  logic [NCH-1:0]       desc_chan_mod,
    input  logic                 elem_done,
    input  logic                 lin_done,
    input  logic [NCH*16-1:0]    chan_off_in,
    output logic [NCH*16-1:0]    chan_addend,
    output logic [NCH*16-1:0]    chan_off_out,
    output logic                 mod_active,
    output logic                 xfer_end
);
    step_state_t    st_q;
    logic [NCH-1:0] flag_q;
    logic           step, col_at, row_at, row_step, end_pulse, sel_mode;

    assign sel_mode = mod_feature_en && (desc_chan_mod != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            flag_q <= '0;
        end else if (desc_load) begin
            st_q.mode <= sel_mode;
            st_q.busy <= sel_mode;
            st_q.skip <= {desc_mod_hi, desc_mod_lo};
            flag_q    <= desc_chan_mod;
        end else if (end_pulse) begin
            st_q.busy <= 1'b0;
        end
    end

    assign step      = st_q.busy && elem_done && !desc_load;
    assign row_step  = step && col_at && !row_at;
    assign end_pulse = step && col_at && row_at;

    mod_axis_counter u_col (
        .clk(clk), .rst(rst), .clear(desc_load), .lim_raw(desc_len_lo),
        .adv(step), .at_lim(col_at)
    );

    mod_axis_counter u_row (
        .clk(clk), .rst(rst), .clear(desc_load), .lim_raw(desc_len_hi),
        .adv(row_step), .at_lim(row_at)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        mod_chan_skip u_skip (
            .flag    (flag_q[c]),
            .row_step(row_step),
            .skip    (st_q.skip),
            .off_in  (chan_off_in[c*OFF_W +: OFF_W]),
            .addend  (chan_addend[c*OFF_W +: OFF_W]),
            .off_out (chan_off_out[c*OFF_W +: OFF_W])
        );
    end

    assign mod_active = st_q.mode;
    assign xfer_end   = st_q.mode ? end_pulse : lin_done;

    // R4: an addend only appears on an element strobe in modulo mode
    a_r4_addend_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (chan_addend != '0) |-> (elem_done && mod_active));
    // R5: an end pulse in modulo mode leaves the stepper idle
    a_r5_end_goes_idle: assert property (@(posedge clk) disable iff (rst)
        (mod_active && xfer_end) |=> !st_q.busy);
    // R7: an idle stepper emits no addend and no modulo end
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !st_q.busy |-> (chan_addend == '0) && !(mod_active && xfer_end));
    // R1: a busy stepper is always in modulo mode
    a_r1_busy_implies_mode: assert property (@(posedge clk) disable iff (rst)
        st_q.busy |-> mod_active);

endmodule

// File: tb/mod_stepper_test.sv
`timescale 1ns/1ps
module mod_stepper_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        en = 0, ld = 0, el = 0, lin = 0;
    logic [7:0]  llo = 0, lhi = 0, mlo = 0, mhi = 0;
    logic [1:0]  fl = 0;
    logic [31:0] offi = 0;
    logic [31:0] add_o, off_o;
    logic        act_o, end_o;

    int total = 0, failed = 0;
    string cur_req = "R1";

    int m_col = 0, m_row = 0, m_cl = 256, m_rl = 256, m_mv = 0;
    bit m_busy = 0, m_mode = 0;
    bit [1:0] m_fl = 0;

    always #4 clk = ~clk;

    mod_stepper #(.NCH(2)) uut (
        .clk(clk), .rst(rst), .mod_feature_en(en), .desc_load(ld),
        .desc_len_lo(llo), .desc_len_hi(lhi), .desc_mod_lo(mlo), .desc_mod_hi(mhi),
        .desc_chan_mod(fl), .elem_done(el), .lin_done(lin), .chan_off_in(offi),
        .chan_addend(add_o), .chan_off_out(off_o), .mod_active(act_o), .xfer_end(end_o)
    );

    task automatic chk(input string what, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, actual, expected);
        end
    endtask

    task automatic tick();
        bit step, colat, rowat, rs, e_end;
        int e_add, e_off;
        #2;
        step  = m_busy && el && !ld;
        colat = (m_col == m_cl);
        rowat = (m_row == m_rl);
        rs    = step && colat && !rowat;
        e_end = m_mode ? (step && colat && rowat) : lin;
        chk("mod_active", int'(act_o), int'(m_mode));
        chk("xfer_end", int'(end_o), int'(e_end));
        for (int c = 0; c < 2; c++) begin
            e_add = (rs && m_fl[c]) ? m_mv : 0;
            e_off = (int'(offi[c*16 +: 16]) + e_add) & 32'hFFFF;
            chk($sformatf("addend ch%0d", c), int'(add_o[c*16 +: 16]), e_add);
            chk($sformatf("off_out ch%0d", c), int'(off_o[c*16 +: 16]), e_off);
        end
        @(posedge clk);
        if (ld) begin
            m_cl = (llo == 0) ? 256 : int'(llo);
            m_rl = (lhi == 0) ? 256 : int'(lhi);
            m_mv = {mhi, mlo};
            m_fl = fl;
            m_mode = en && (fl != 0);
            m_busy = m_mode;
            m_col = 0; m_row = 0;
        end else if (step) begin
            if (colat) begin
                if (rowat) begin m_busy = 0; m_col = 0; end
                else begin m_col = 0; m_row++; end
            end else m_col++;
        end
        @(negedge clk);
    endtask

    task automatic load(input bit e, input int lo, input int hi, input int mv, input bit [1:0] f);
        en = e; ld = 1; llo = lo[7:0]; lhi = hi[7:0]; mlo = mv[7:0]; mhi = mv[15:8]; fl = f;
        el = 0;
        tick();
        ld = 0;
    endtask

    task automatic run(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            el = 1; lin = (i % 3 == 0);
            tick();
            if (gaps && (i % 2 == 1)) begin el = 0; lin = 0; tick(); end
        end
        el = 0; lin = 0;
    endtask

    initial begin
        #(8ns * 200000);
        failed++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        offi = {16'h2000, 16'h1000};
        repeat (3) @(negedge clk);
        rst = 0;
        cur_req = "R1"; tick();   // reset state: passthrough, no addend
        lin = 1; tick(); lin = 0;

        // R1: feature off -> linear passthrough despite flags
        cur_req = "R1";
        load(0, 2, 1, 16'h0104, 2'b11);
        run(8, 0);

        // R4/R5/R9: 3 columns x 2 rows, source channel only, skip 0x0104
        cur_req = "R4";
        load(1, 2, 1, 16'h0104, 2'b01);
        cur_req = "R5"; run(6, 1);
        // R7: strobes after end are ignored
        cur_req = "R7"; run(4, 0);

        // R8/R3: reload in the same cycle as a strobe restarts counting
        cur_req = "R8";
        load(1, 1, 1, 16'h0010, 2'b10);
        run(1, 0);
        en = 1; ld = 1; llo = 3; lhi = 0; mlo = 8'h22; mhi = 8'h11; fl = 2'b11; el = 1;
        tick();
        ld = 0; el = 0;
        cur_req = "R3"; run(4 * 256 + 4, 0);

        // R2: zero column limit, then zero row limit
        cur_req = "R2";
        load(1, 0, 2, 16'h0300, 2'b11);
        run(771, 0);
        load(1, 1, 0, 16'h0001, 2'b01);
        run(514, 0);

        // R6: offset wraps within 16 bits
        cur_req = "R6";
        offi = {16'hFFE0, 16'hFFF0};
        load(1, 1, 1, 16'h0020, 2'b11);
        run(4, 0);
        cur_req = "R9";
        load(1, 0, 1, 16'hA55A, 2'b10);
        run(514, 1);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule